// File: doc/BRIEF.md
# Phase Comparator with Lock Detector

This block sits in the digital half of a frequency synthesizer loop. It takes two single-cycle strobes, one from the divided reference path and one from the divided oscillator path, both synchronous to the reference oscillator clock `clk`. A pair of edge-capturing flags records which strobe came first. From that state it drives a three-state charge-pump control (a level plus an output enable), two comparator monitor outputs, and one shared output. Depending on a select input, the shared output carries either a lock flag or a copy of one of the incoming strobes.

The width of every phase error is measured in `clk` cycles. A wide error clears the lock flag at once. The flag is set again only after a run of consecutive comparisons whose error stayed narrow. A polarity input swaps the sense of the charge-pump and monitor outputs, which lets the block suit loop filters and oscillators of either tuning slope. A power-save input parks the loop in its hold state. A separate enable can take the charge-pump output off the line at any time.

Top module: `phcmp_lock`

## Requirements
- R1: With `pol_i`=1, `cp_oe_o` is 1 with `cp_val_o`=1 while only the reference flag is set (reference strobe arrived first), and 1 with `cp_val_o`=0 while only the oscillator flag is set. With neither flag or both flags set, `cp_oe_o` is 0.
- R2: With `pol_i`=0, the drive levels of R1 are swapped: `cp_val_o`=0 while only the reference flag is set, and 1 while only the oscillator flag is set.
- R3: `mon_r_o` is high while the flag that drives the charge pump low is set. `mon_p_pull_o` (1 = open-drain pull active) is high while the flag that drives it high is set. With `pol_i`=1 these are the oscillator flag and the reference flag respectively; `pol_i`=0 swaps them.
- R4: Each flag is set on the cycle after its strobe. When both flags are set, both clear on the next edge, and only strobes arriving in that clearing cycle are kept. Coincident strobes therefore give a one-cycle pulse on both monitor outputs, with `cp_oe_o` staying 0.
- R5: The error width is the number of cycles in which exactly one flag is set. In the cycle where that width reaches `WU_CNT`, the lock state clears on that edge and the run count restarts.
- R6: A comparison ends in a cycle with both flags set. It counts as narrow if its width was at most `WL_CNT`. The lock state is set on the edge that completes `LOCK_RUN` consecutive narrow comparisons. A wider comparison resets the run.
- R7: With `mon_sel_i`=1, `ld_o` follows `fr_i` when `pol_i`=1 and `fp_i` when `pol_i`=0. With `mon_sel_i`=0, `ld_o` is the lock flag.
- R8: While `psave_i`=1: `cp_oe_o` and both monitors are 0, the lock flag reads 1, strobes are ignored, and both flags and the width count clear. After release, the flags start cleared and the lock state stays 1.
- R9: While `cp_en_i`=0, `cp_oe_o` is 0 whatever the comparator state.
- R10: Synchronous reset clears both flags, the width and run counts, and the lock state (lock flag 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_i | input | 1 | Divided reference strobe |
| fp_i | input | 1 | Divided oscillator strobe |
| pol_i | input | 1 | Comparator polarity |
| mon_sel_i | input | 1 | 1 = strobe monitor on `ld_o`, 0 = lock flag |
| psave_i | input | 1 | Power-save hold |
| cp_en_i | input | 1 | 0 forces charge-pump output off |
| cp_val_o | output | 1 | Charge-pump drive level |
| cp_oe_o | output | 1 | Charge-pump output enable |
| mon_r_o | output | 1 | Push-pull comparator monitor |
| mon_p_pull_o | output | 1 | Open-drain comparator monitor pull |
| ld_o | output | 1 | Lock flag or strobe monitor |

## Verification
The bench builds the block with `WU_CNT`=6, `WL_CNT`=2 and `LOCK_RUN`=3. With these values, unlock, relock and the band between the two thresholds can all be reached with strobe gaps of a few cycles. Gaps of 3 to 5 cycles fall in that middle band: they neither clear the lock state nor count toward a lock run. Gaps of 6 or more clear the lock state in the middle of a comparison.

// File: rtl/phcmp_pkg.sv
package phcmp_pkg;

    localparam int DEF_WU_CNT   = 12;
    localparam int DEF_WL_CNT   = 4;
    localparam int DEF_LOCK_RUN = 3;

    typedef struct packed {
        logic ref_lead;
        logic vco_lead;
    } pfd_state_t;

    typedef enum logic [1:0] {
        CMP_IDLE = 2'd0,
        CMP_REF  = 2'd1,
        CMP_VCO  = 2'd2,
        CMP_BOTH = 2'd3
    } cmp_phase_e;

    typedef struct packed {
        logic oe;
        logic val;
    } tri_out_t;

    function automatic cmp_phase_e classify(pfd_state_t s);
        case ({s.ref_lead, s.vco_lead})
            2'b10:   return CMP_REF;
            2'b01:   return CMP_VCO;
            2'b11:   return CMP_BOTH;
            default: return CMP_IDLE;
        endcase
    endfunction

    // Charge-up flag: which lead drives the output high for a polarity.
    function automatic logic up_flag(pfd_state_t s, logic pol);
        return pol ? s.ref_lead : s.vco_lead;
    endfunction

    function automatic logic dn_flag(pfd_state_t s, logic pol);
        return pol ? s.vco_lead : s.ref_lead;
    endfunction

endpackage

// File: rtl/phcmp_flops.sv
module phcmp_flops
    import phcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       psave_i,
    input  logic       fr_i,
    input  logic       fp_i,
    output pfd_state_t st_o
);

    pfd_state_t st_q;
    logic       both;

    assign both = st_q.ref_lead & st_q.vco_lead;

    always_ff @(posedge clk) begin
        if (rst || psave_i) begin
            st_q <= '0;
        end else if (both) begin
            st_q.ref_lead <= fr_i;
            st_q.vco_lead <= fp_i;
        end else begin
            st_q.ref_lead <= st_q.ref_lead | fr_i;
            st_q.vco_lead <= st_q.vco_lead | fp_i;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/phcmp_lockdet.sv
module phcmp_lockdet
    import phcmp_pkg::*;
#(
    parameter int WU_CNT   = DEF_WU_CNT,
    parameter int WL_CNT   = DEF_WL_CNT,
    parameter int LOCK_RUN = DEF_LOCK_RUN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       psave_i,
    input  pfd_state_t st_i,
    output logic       lock_q_o
);

    localparam int ERR_W = $clog2(WU_CNT + 1);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [ERR_W-1:0] WU_LIM  = ERR_W'(WU_CNT);
    localparam logic [ERR_W-1:0] WL_LIM  = ERR_W'(WL_CNT);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(LOCK_RUN);

    logic [ERR_W-1:0] err_q, err_n;
    logic [RUN_W-1:0] run_q, run_inc;
    logic             lock_q;
    cmp_phase_e       phase;

    assign phase = classify(st_i);

    always_comb begin
        err_n   = (err_q >= WU_LIM)  ? err_q : err_q + 1'b1;
        run_inc = (run_q >= RUN_LIM) ? run_q : run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (psave_i) begin
            err_q  <= '0;
            run_q  <= '0;
            lock_q <= 1'b1;
        end else begin
            case (phase)
                CMP_REF, CMP_VCO: begin
                    err_q <= err_n;
                    if (err_n >= WU_LIM) begin
                        lock_q <= 1'b0;
                        run_q  <= '0;
                    end
                end
                CMP_BOTH: begin
                    err_q <= '0;
                    if (err_q <= WL_LIM) begin
                        run_q <= run_inc;
                        if (run_inc >= RUN_LIM) lock_q <= 1'b1;
                    end else begin
                        run_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign lock_q_o = lock_q;

endmodule

// File: rtl/phcmp_outsel.sv
module phcmp_outsel
    import phcmp_pkg::*;
(
    input  pfd_state_t st_i,
    input  logic       pol_i,
    input  logic       psave_i,
    input  logic       cp_en_i,
    input  logic       mon_sel_i,
    input  logic       fr_i,
    input  logic       fp_i,
    input  logic       lock_q_i,
    output tri_out_t   cp_o,
    output logic       mon_r_o,
    output logic       mon_p_pull_o,
    output logic       ld_o
);

    logic up, dn, live, lock_flag, strobe_mon;

    always_comb begin
        up         = up_flag(st_i, pol_i);
        dn         = dn_flag(st_i, pol_i);
        live       = ~psave_i;
        cp_o.oe    = cp_en_i & live & (up ^ dn);
        cp_o.val   = up;
        mon_r_o      = dn & live;
        mon_p_pull_o = up & live;
        lock_flag  = lock_q_i | psave_i;
        strobe_mon = pol_i ? fr_i : fp_i;
        ld_o       = mon_sel_i ? strobe_mon : lock_flag;
    end

endmodule

// File: rtl/phcmp_lock.sv
module phcmp_lock
    import phcmp_pkg::*;
#(
    parameter int WU_CNT   = DEF_WU_CNT,
    parameter int WL_CNT   = DEF_WL_CNT,
    parameter int LOCK_RUN = DEF_LOCK_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic fr_i,
    input  logic fp_i,
    input  logic pol_i,
    input  logic mon_sel_i,
    input  logic psave_i,
    input  logic cp_en_i,
    output logic cp_val_o,
    output logic cp_oe_o,
    output logic mon_r_o,
    output logic mon_p_pull_o,
    output logic ld_o
);

    pfd_state_t st;
    tri_out_t   cp;
    logic       lock_hold;

    phcmp_flops u_flops (
        .clk     (clk),
        .rst     (rst),
        .psave_i (psave_i),
        .fr_i    (fr_i),
        .fp_i    (fp_i),
        .st_o    (st)
    );

    phcmp_lockdet #(
        .WU_CNT   (WU_CNT),
        .WL_CNT   (WL_CNT),
        .LOCK_RUN (LOCK_RUN)
    ) u_lockdet (
        .clk      (clk),
        .rst      (rst),
        .psave_i  (psave_i),
        .st_i     (st),
        .lock_q_o (lock_hold)
    );

    phcmp_outsel u_outsel (
        .st_i         (st),
        .pol_i        (pol_i),
        .psave_i      (psave_i),
        .cp_en_i      (cp_en_i),
        .mon_sel_i    (mon_sel_i),
        .fr_i         (fr_i),
        .fp_i         (fp_i),
        .lock_q_i     (lock_hold),
        .cp_o         (cp),
        .mon_r_o      (mon_r_o),
        .mon_p_pull_o (mon_p_pull_o),
        .ld_o         (ld_o)
    );

    assign cp_val_o = cp.val;
    assign cp_oe_o  = cp.oe;

endmodule

// File: rtl/phcmp_lock_chk.sv
module phcmp_lock_chk (
    input logic clk,
    input logic rst,
    input logic fr_i,
    input logic fp_i,
    input logic psave_i,
    input logic cp_en_i,
    input logic mon_sel_i,
    input logic cp_oe_o,
    input logic ld_o,
    input logic ref_st,
    input logic vco_st,
    input logic lock_hold
);

    // R4
    both_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_st && vco_st && !(fr_i && fp_i)) |=> !(ref_st && vco_st));

    // R9
    cp_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cp_en_i |-> !cp_oe_o);

    // R8
    psave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (psave_i && !mon_sel_i) |-> (ld_o && !cp_oe_o));

    // R8
    psave_clear_chk: assert property (@(posedge clk) disable iff (rst)
        psave_i |=> (!ref_st && !vco_st));

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(lock_hold) && !$past(psave_i)) |-> $past(ref_st && vco_st));

    // R5
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_hold) |-> $past(ref_st ^ vco_st));

endmodule

bind phcmp_lock phcmp_lock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fr_i      (fr_i),
    .fp_i      (fp_i),
    .psave_i   (psave_i),
    .cp_en_i   (cp_en_i),
    .mon_sel_i (mon_sel_i),
    .cp_oe_o   (cp_oe_o),
    .ld_o      (ld_o),
    .ref_st    (st.ref_lead),
    .vco_st    (st.vco_lead),
    .lock_hold (lock_hold)
);

// File: tb/phcmp_lock_bench.sv
module phcmp_lock_bench;

    localparam int PERIOD = 10;
    localparam int WU = 6;
    localparam int WL = 2;
    localparam int RUN = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fr = 1'b0, fp = 1'b0, pol = 1'b1, msel = 1'b0, ps = 1'b0, cpen = 1'b1;
    logic cp_val, cp_oe, mon_r, mon_p, ld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    int mr = 0, mv = 0, me = 0, mrun = 0, ml = 0;

    always #(PERIOD/2) clk = ~clk;

    phcmp_lock #(.WU_CNT(WU), .WL_CNT(WL), .LOCK_RUN(RUN)) u_phcmp_lock (
        .clk(clk), .rst(rst), .fr_i(fr), .fp_i(fp), .pol_i(pol),
        .mon_sel_i(msel), .psave_i(ps), .cp_en_i(cpen),
        .cp_val_o(cp_val), .cp_oe_o(cp_oe), .mon_r_o(mon_r),
        .mon_p_pull_o(mon_p), .ld_o(ld)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mr = 0; mv = 0; me = 0; mrun = 0; ml = 0;
        end else if (ps) begin
            mr = 0; mv = 0; me = 0; mrun = 0; ml = 1;
        end else if (mr == 1 && mv == 1) begin
            if (me <= WL) begin
                if (mrun < RUN) mrun = mrun + 1;
                if (mrun >= RUN) ml = 1;
            end else begin
                mrun = 0;
            end
            me = 0; mr = int'(fr); mv = int'(fp);
        end else if (mr != mv) begin
            if (me < WU) me = me + 1;
            if (me >= WU) begin ml = 0; mrun = 0; end
            if (fr) mr = 1;
            if (fp) mv = 1;
        end else begin
            mr = int'(fr); mv = int'(fp);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int up, dn, e_oe, e_ld;
            up = pol ? mr : mv;
            dn = pol ? mv : mr;
            e_oe = (cpen && !ps && (up != dn)) ? 1 : 0;
            e_ld = msel ? int'(pol ? fr : fp) : ((ml == 1 || ps) ? 1 : 0);
            if (!cpen)    chk("R9 cp_oe", cp_oe, e_oe[0]);
            else if (ps)  chk("R8 cp_oe", cp_oe, e_oe[0]);
            else          chk("R4 cp_oe", cp_oe, e_oe[0]);
            if (e_oe == 1) chk(pol ? "R1 cp_val" : "R2 cp_val", cp_val, up[0]);
            chk("R3 mon_r", mon_r, (ps ? 1'b0 : dn[0]));
            chk("R3 mon_p", mon_p, (ps ? 1'b0 : up[0]));
            chk(msel ? "R7 ld" : "R5 R6 ld", ld, e_ld[0]);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // first strobe, then the other gap cycles later (gap 0: coincident)
    task automatic pair(input bit ref_first, input int gap, input int idle);
        step();
        if (gap == 0) begin fr = 1; fp = 1; end
        else if (ref_first) fr = 1;
        else fp = 1;
        step();
        fr = 0; fp = 0;
        if (gap > 0) begin
            repeat (gap - 1) step();
            if (ref_first) fp = 1; else fr = 1;
            step();
            fr = 0; fp = 0;
        end
        repeat (idle) step();
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) step();
        at_neg();
        // R10
        chk("R10 ld after reset", ld, 1'b0);
        chk("R10 cp_oe after reset", cp_oe, 1'b0);
        step();
        rst = 0;

        // R1: reference leads, drive high
        pol = 1;
        step(); fr = 1; step(); fr = 0;
        at_neg();
        chk("R1 drive level", cp_val, 1'b1);
        chk("R1 drive enable", cp_oe, 1'b1);
        repeat (2) step(); fp = 1; step(); fp = 0;
        at_neg();
        chk("R4 both set, undriven", cp_oe, 1'b0);
        step();
        at_neg();
        chk("R4 cleared after both", mon_r | mon_p, 1'b0);

        // R6: three narrow comparisons lock
        pair(1, 1, 2);
        pair(0, 2, 2);
        at_neg();
        chk("R6 not yet locked", ld, 1'b0);
        pair(1, 0, 2);
        at_neg();
        chk("R6 locked after run", ld, 1'b1);

        // middle band: neither unlock nor lock progress
        pair(1, 4, 2);
        at_neg();
        chk("R5 mid error keeps lock", ld, 1'b1);

        // R5: wide error unlocks mid-comparison
        step(); fr = 1; step(); fr = 0;
        repeat (WU - 1) step();
        at_neg();
        chk("R5 still locked before limit", ld, 1'b1);
        step();
        at_neg();
        chk("R5 unlocked at limit", ld, 1'b0);
        fp = 1; step(); fp = 0; repeat (2) step();

        // R2: polarity reversed
        pol = 0;
        step(); fr = 1; step(); fr = 0;
        at_neg();
        chk("R2 reversed drive", cp_val, 1'b0);
        step(); fp = 1; step(); fp = 0; repeat (2) step();

        // R7: monitor select
        msel = 1;
        step(); fp = 1;
        at_neg();
        chk("R7 monitor follows fp", ld, 1'b1);
        step(); fp = 0; fr = 1;
        at_neg();
        chk("R7 monitor ignores fr", ld, 1'b0);
        step(); fr = 0; repeat (3) step();
        msel = 0;

        // R9: force off
        cpen = 0;
        step(); fr = 1; step(); fr = 0;
        at_neg();
        chk("R9 forced off", cp_oe, 1'b0);
        step(); fp = 1; step(); fp = 0; repeat (2) step();
        cpen = 1;

        // R8: power save
        pol = 1;
        step(); fr = 1; step(); fr = 0; ps = 1;
        at_neg();
        chk("R8 undriven in save", cp_oe, 1'b0);
        chk("R8 lock flag high in save", ld, 1'b1);
        step(); fp = 1; step(); fp = 0; step();
        ps = 0;
        at_neg();
        chk("R8 flags cleared on release", mon_r | mon_p, 1'b0);
        chk("R8 lock held on release", ld, 1'b1);
        repeat (2) step();

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int g;
            g = int'($urandom_range(0, 8));
            pol  = 1'($urandom_range(0, 1));
            msel = ($urandom_range(0, 9) == 0);
            cpen = ($urandom_range(0, 9) != 0);
            ps   = ($urandom_range(0, 19) == 0);
            pair(1'($urandom_range(0, 1)), g, int'($urandom_range(0, 3)));
            ps = 0;
        end
        repeat (3) step();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule